// File: doc/BRIEF.md
# Scannable Registered Bus Transceiver

This block is a narrow registered transceiver that sits between a core and a shared bus. A transmit register takes data from the core-side inputs and drives it onto the bus. A receive register captures what the bus carries and presents it to the core. Each register has its own load control. When that control is low the register keeps its value through a feedback path. All data paths are non-inverting.

A single enable flip-flop decides whether the bus drivers are active. When it is clear, every bus line is released to high impedance. Logic normally sets it synchronously. An asynchronous off input can clear it at any moment, which takes the bus off before a scan test. An asynchronous force-on input sets it at once and overrides the off input. When the force-on input is held low, the only way to re-enable the bus is through the synchronous enable.

While scan mode is high, the two registers form one serial chain. The serial input feeds transmit bit 0, which shifts up to the top transmit bit, then into receive bit 0, and on up to the top receive bit. The top receive output bit is the chain output.

Top module: `scan_bus_xcvr`

## Requirements
- R1: With `scan_mode` low and `tx_load` high, the transmit register takes `a_in` on the rising clock edge. Whenever the bus is enabled it appears on `bus_out` with the same polarity.
- R2: With `scan_mode` low and `tx_load` low, the transmit register keeps its value across the clock edge, whatever `a_in` is.
- R3: With `scan_mode` low and `rx_load` high, the receive register takes `b_in` on the rising clock edge and shows it unchanged on `rx_q`.
- R4: With `scan_mode` low and `rx_load` low, `rx_q` keeps its value across the clock edge, whatever `b_in` is.
- R5: While `rst_n` is low, both registers are zero and the bus is disabled: `bus_oe` is 0 and `bus_out` is all Z.
- R6: When the bus enable is clear, `bus_out` is all high-impedance (Z) and `bus_oe` is 0. When it is set, `bus_out` equals the transmit register and `bus_oe` is 1.
- R7: If `bus_en_sync` is high at a rising edge while `bus_off_async` and `bus_force_on` are low, the enable is set after that edge. If `bus_en_sync` is low, the edge leaves the enable unchanged.
- R8: A rising `bus_off_async` clears the enable at once, between clock edges. While it stays high, clock edges keep the enable clear unless `bus_force_on` is high.
- R9: A high `bus_force_on` sets the enable at once, without a clock edge, even while `bus_off_async` is high.
- R10: With `scan_mode` high, each rising edge shifts the chain `scan_in` → tx[0] → tx[1] → tx[2] → rx[0] → rx[1] → rx[2]. `rx_q[2]` is the chain output. `tx_load` and `rx_load` are ignored, and 6 edges reload the whole chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | WIDTH | Transmit-side parallel data |
| b_in | input | WIDTH | Bus data as seen by the receiver |
| tx_load | input | 1 | Transmit register load (1) / hold (0) |
| rx_load | input | 1 | Receive register load (1) / hold (0) |
| scan_mode | input | 1 | Selects serial shift through both registers |
| scan_in | input | 1 | Serial chain input |
| bus_en_sync | input | 1 | Clocked set of the bus enable |
| bus_off_async | input | 1 | Asynchronous clear of the bus enable |
| bus_force_on | input | 1 | Asynchronous set of the bus enable, overrides the clear |
| bus_out | output | WIDTH | Tri-state bus drive |
| bus_oe | output | 1 | Bus enable flip-flop state |
| rx_q | output | WIDTH | Receive outputs; top bit is the chain output in scan mode |

## Verification
The bench drives the load path with alternating, complementary and all-ones words on `a_in` and `b_in`. This shows that each side loads the correct source without inversion, and that holding keeps the old word even while the inputs change. It then drives the enable with a mid-cycle clear, a force-on pulse that overlaps an active clear, and synchronous re-enables with the force-on input low. These separate the immediate paths from the clocked path. A six-bit serial pattern with both load controls held high checks the chain order and confirms that shifting overrides loading.

// File: rtl/scan_xcvr_pkg.sv
`timescale 1ns/1ps
package scan_xcvr_pkg;
   typedef enum logic {
      BUS_RELEASED = 1'b0,
      BUS_DRIVEN   = 1'b1
   } bus_state_e;
endpackage

// File: rtl/xcvr_side_reg.sv
`timescale 1ns/1ps
module xcvr_side_reg #(
   parameter int WIDTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             scan_i,
   input  logic             ser_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("xcvr_side_reg: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] shifted;

   generate
      if (WIDTH == 1) begin : g_shift_one
         assign shifted = ser_i;
      end else begin : g_shift_many
         assign shifted = {q_o[WIDTH-2:0], ser_i};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= '0;
      else if (scan_i) q_o <= shifted;
      else if (load_i) q_o <= d_i;
   end

   // R1 / R3: parallel load captures the data input
   a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_i && load_i) |=> (q_o == $past(d_i)));

   // R2 / R4: hold keeps the value
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_i && !load_i) |=> $stable(q_o));

   // R10: serial input enters the lowest bit
   a_r10_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      scan_i |=> (q_o[0] == $past(ser_i)));
endmodule

// File: rtl/bus_enable_ff.sv
`timescale 1ns/1ps
module bus_enable_ff #(
   parameter bit HAS_FORCE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_i,
   input  logic off_i,
   input  logic force_i,
   output logic en_o
);
   import scan_xcvr_pkg::*;

   bus_state_e state;
   logic       force_eff;

   generate
      if (HAS_FORCE) begin : g_force
         assign force_eff = force_i;
      end else begin : g_no_force
         assign force_eff = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n or posedge off_i or posedge force_eff) begin
      if (!rst_n)         state <= BUS_RELEASED;
      else if (force_eff) state <= BUS_DRIVEN;
      else if (off_i)     state <= BUS_RELEASED;
      else if (sync_i)    state <= BUS_DRIVEN;
   end

   assign en_o = (state == BUS_DRIVEN);

   // R8: a clear held across a whole cycle with no set keeps the bus off
   a_r8_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (off_i && $past(off_i) && !force_eff && !$past(force_eff)) |-> !en_o);

   // R9: the overriding set wins over the clear
   a_r9_force_wins: assert property (@(posedge clk) disable iff (!rst_n)
      force_eff |-> en_o);

   // R7: without a request and without a set, the enable never rises on an edge
   a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_o && !sync_i && !force_eff) |=> (!en_o || $past(force_eff) || force_eff));
endmodule

// File: rtl/scan_bus_xcvr.sv
`timescale 1ns/1ps
module scan_bus_xcvr #(
   parameter int WIDTH     = 3,
   parameter bit HAS_FORCE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             tx_load,
   input  logic             rx_load,
   input  logic             scan_mode,
   input  logic             scan_in,
   input  logic             bus_en_sync,
   input  logic             bus_off_async,
   input  logic             bus_force_on,
   output logic [WIDTH-1:0] bus_out,
   output logic             bus_oe,
   output logic [WIDTH-1:0] rx_q
);
   localparam int TOP = WIDTH - 1;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("scan_bus_xcvr: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] tx_q;
   logic             bus_en;

   xcvr_side_reg #(.WIDTH(WIDTH)) u_tx (
      .clk(clk), .rst_n(rst_n), .load_i(tx_load), .scan_i(scan_mode),
      .ser_i(scan_in), .d_i(a_in), .q_o(tx_q)
   );

   xcvr_side_reg #(.WIDTH(WIDTH)) u_rx (
      .clk(clk), .rst_n(rst_n), .load_i(rx_load), .scan_i(scan_mode),
      .ser_i(tx_q[TOP]), .d_i(b_in), .q_o(rx_q)
   );

   bus_enable_ff #(.HAS_FORCE(HAS_FORCE)) u_en (
      .clk(clk), .rst_n(rst_n), .sync_i(bus_en_sync), .off_i(bus_off_async),
      .force_i(bus_force_on), .en_o(bus_en)
   );

   assign bus_oe  = bus_en;
   assign bus_out = bus_en ? tx_q : {WIDTH{1'bz}};

   // R10: the chain crosses from the top transmit bit into the receive side
   a_r10_chain_link: assert property (@(posedge clk) disable iff (!rst_n)
      scan_mode |=> (rx_q[0] == $past(tx_q[TOP])));
endmodule

// File: tb/tb_scan_bus_xcvr.sv
`timescale 1ns/1ps
module tb_scan_bus_xcvr;
   localparam int W = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic         tx_load = 0, rx_load = 0, scan_mode = 0, scan_in = 0;
   logic         bus_en_sync = 0, bus_off_async = 0, bus_force_on = 0;
   wire  [W-1:0] bus_out;
   wire          bus_oe;
   wire  [W-1:0] rx_q;

   scan_bus_xcvr #(.WIDTH(W)) dut (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .tx_load(tx_load), .rx_load(rx_load), .scan_mode(scan_mode), .scan_in(scan_in),
      .bus_en_sync(bus_en_sync), .bus_off_async(bus_off_async), .bus_force_on(bus_force_on),
      .bus_out(bus_out), .bus_oe(bus_oe), .rx_q(rx_q)
   );

   always #4 clk = ~clk;

   int total = 0;
   int bad   = 0;

   typedef struct {
      string        tag;
      logic [W-1:0] tx;
      logic [W-1:0] rx;
      logic         en;
   } exp_t;

   exp_t sb[$];
   logic [W-1:0] tx_m = '0, rx_m = '0;
   logic         en_m = 1'b0;

   task automatic compare(string tag, logic [W-1:0] tx, logic [W-1:0] rx, logic en);
      logic [W-1:0] exp_bus;
      exp_bus = en ? tx : {W{1'bz}};
      total++;
      if (rx_q !== rx || bus_oe !== en || bus_out !== exp_bus) begin
         bad++;
         $display("FAIL %s: rx_q=%b oe=%b bus=%b expected rx_q=%b oe=%b bus=%b",
                  tag, rx_q, bus_oe, bus_out, rx, en, exp_bus);
      end
   endtask

   // monitor: pops expectations and compares after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            compare(e.tag, e.tx, e.rx, e.en);
         end
      end
   end

   // driver: applies one cycle and pushes the model's expected result
   task automatic step(string tag, logic [W-1:0] a, logic [W-1:0] b,
                       logic tl, logic rl, logic sc, logic si, logic se);
      exp_t e;
      @(negedge clk);
      a_in = a; b_in = b; tx_load = tl; rx_load = rl;
      scan_mode = sc; scan_in = si; bus_en_sync = se;
      @(posedge clk);
      if (sc) begin
         rx_m = {rx_m[W-2:0], tx_m[W-1]};
         tx_m = {tx_m[W-2:0], si};
      end else begin
         if (tl) tx_m = a;
         if (rl) rx_m = b;
      end
      if (bus_force_on)       en_m = 1'b1;
      else if (bus_off_async) en_m = 1'b0;
      else if (se)            en_m = 1'b1;
      #1;
      e.tag = tag; e.tx = tx_m; e.rx = rx_m; e.en = en_m;
      sb.push_back(e);
   endtask

   initial begin
      #(8 * 20000);
      bad++; total++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #3;
      compare("R5 reset state", '0, '0, 1'b0);
      @(negedge clk); rst_n = 1'b1;

      // R7: no sync request, enable stays off
      step("R7 no request keeps bus off", 3'b000, 3'b000, 0, 0, 0, 0, 0);
      // R1 load while disabled, R6 bus still released
      step("R1/R6 load while released", 3'b101, 3'b000, 1, 0, 0, 0, 0);
      // R7 synchronous enable
      step("R7 sync enable sets", 3'b101, 3'b000, 0, 0, 0, 0, 1);
      step("R1 load 010 onto bus", 3'b010, 3'b000, 1, 0, 0, 0, 0);
      step("R2 hold with a_in changed", 3'b111, 3'b000, 0, 0, 0, 0, 0);
      step("R3 receive load 110", 3'b000, 3'b110, 0, 1, 0, 0, 0);
      step("R4 receive hold with b_in changed", 3'b000, 3'b001, 0, 0, 0, 0, 0);
      step("R3 receive load 011", 3'b000, 3'b011, 0, 1, 0, 0, 0);
      step("R1 load 111 non-inverted", 3'b111, 3'b011, 1, 0, 0, 0, 0);

      // R8: asynchronous disable mid-cycle
      @(negedge clk); #1;
      bus_off_async = 1'b1; en_m = 1'b0;
      #1;
      compare("R8 mid-cycle disable", tx_m, rx_m, 1'b0);
      step("R8 disable held across edge", 3'b111, 3'b000, 0, 0, 0, 0, 1);

      // R9: overriding set while disable is high
      @(negedge clk); #1;
      bus_force_on = 1'b1; en_m = 1'b1;
      #1;
      compare("R9 force-on overrides disable", tx_m, rx_m, 1'b1);
      step("R9 force-on holds across edge", 3'b000, 3'b000, 0, 0, 0, 0, 0);
      @(negedge clk); bus_force_on = 1'b0;
      step("R8 disable returns after force drops", 3'b000, 3'b000, 0, 0, 0, 0, 0);
      @(negedge clk); bus_off_async = 1'b0;
      step("R7 sync re-enable with force low", 3'b000, 3'b000, 0, 0, 0, 0, 1);

      // R10: full scan shift, load controls high to prove override
      step("R10 scan bit 1", 3'b000, 3'b111, 1, 1, 1, 1, 0);
      step("R10 scan bit 2", 3'b000, 3'b111, 1, 1, 1, 0, 0);
      step("R10 scan bit 3", 3'b000, 3'b111, 1, 1, 1, 1, 0);
      step("R10 scan bit 4", 3'b000, 3'b111, 1, 1, 1, 1, 0);
      step("R10 scan bit 5", 3'b000, 3'b111, 1, 1, 1, 0, 0);
      step("R10 scan bit 6", 3'b000, 3'b111, 1, 1, 1, 0, 0);
      step("R10 shift out", 3'b000, 3'b111, 0, 0, 1, 0, 0);
      step("R2/R4 hold after scan", 3'b010, 3'b101, 0, 0, 0, 0, 0);

      // R5: reset mid-run clears everything
      @(negedge clk); rst_n = 1'b0;
      tx_m = '0; rx_m = '0; en_m = 1'b0;
      #1;
      compare("R5 reset during run", tx_m, rx_m, en_m);
      @(negedge clk); rst_n = 1'b1;

      repeat (2) @(posedge clk);
      #3;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule